// File: doc/BRIEF.md
# Windowed Byte Register Bridge

This block lets a 32-bit host register port reach a private bank of 256 byte-wide registers through one shared window word. In a single host write the window takes an 8-bit internal address, an 8-bit write byte and a direction flag. The bridge then runs the internal access over a fixed number of clocks and shows a busy flag in the window for that time. When the access is a read, the fetched byte appears in the top byte of the same window word once busy has dropped. The host therefore polls busy before it starts an access, and for a read it polls again before it collects the result.

Next to the window sit three interrupt registers: an enable mask, a write-one-to-clear register and a sticky status register. Each has two sources, transmit and receive. The interrupt output is high while any status bit is set and its mask bit is also set.

The window sequencer is a three-state machine. ST_IDLE waits for a window write and goes to ST_ISSUE when one arrives. ST_ISSUE drives the bank strobe for one cycle and goes to ST_WAIT. ST_WAIT counts out the rest of the latency, captures the bank's byte on its first cycle and returns to ST_IDLE when the count ends. Busy is high in ST_ISSUE and ST_WAIT. The host picks a register with a 2-bit select: 0 is the window, 1 the mask, 2 the clear register and 3 the status register.

Top module: `regwin_bridge`

## Requirements
- R1: A read of the window returns the address in bits 7:0, the write byte in bits 15:8, the direction (0 read, 1 write) in bit 16, busy in bit 23 and the last read byte in bits 31:24. Bits 22:17 read as zero.
- R2: A window write accepted while idle raises busy on the following cycle. Busy then stays high for exactly LATENCY cycles (2 to 4, default 3).
- R3: A write transaction gives exactly one bank write strobe, in the first busy cycle, carrying the captured address and byte. No read strobe occurs.
- R4: A read transaction gives exactly one bank read strobe. Once busy is low, bits 31:24 hold the byte the bank returned. A write transaction leaves bits 31:24 unchanged.
- R5: A window write that arrives while busy is high is ignored. It causes no strobe, does not change the address, byte or direction fields, and does not lengthen busy.
- R6: Status bit 1 is set by a transmit event and bit 2 by a receive event. Once set, a bit stays set until it is cleared.
- R7: Writing the clear register with a 1 in bit 1 or bit 2 clears that status bit. A 0 in a bit leaves that status bit unchanged.
- R8: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: The mask register is active high. The interrupt output is the OR over both sources of status AND mask.
- R10: After reset the window reads zero, busy is low, the mask and status read zero and the interrupt output is low.
- R11: Writes to the status register have no effect. The clear register reads zero. The mask keeps only bits 1 and 2, and all other mask bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the selected register |
| host_sel | input | 2 | Register select: 0 window, 1 mask, 2 clear, 3 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Contents of the selected register, combinational |
| tx_evt | input | 1 | Transmit interrupt event, one cycle per event |
| rx_evt | input | 1 | Receive interrupt event, one cycle per event |
| irq | output | 1 | Interrupt request |
| bank_addr | output | 8 | Byte address to the internal bank |
| bank_wdata | output | 8 | Write byte to the internal bank |
| bank_we | output | 1 | Bank write strobe |
| bank_re | output | 1 | Bank read strobe |
| bank_rdata | input | 8 | Bank read byte, valid one cycle after a read strobe |

## Verification
The assertions rely on a few conditions at the inputs. The bank must return its byte on the cycle after a read strobe and hold it there. Events and host writes must be single-cycle values driven away from the clock edge. The parameter LATENCY must stay between 2 and 4. The bench models the bank as a registered memory with exactly that one-cycle timing. It changes every input on the falling edge and uses the default latency. It polls busy before every access, except for the one test that deliberately writes into a busy window.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } win_state_e;

    // host register selects
    localparam logic [1:0] SEL_WIN  = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_CLR  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    // window word field positions
    localparam int WIN_ADDR_LSB = 0;
    localparam int WIN_WDAT_LSB = 8;
    localparam int WIN_DIR_BIT  = 16;
    localparam int WIN_BUSY_BIT = 23;
    localparam int WIN_RDAT_LSB = 24;

    // lowest interrupt bit in mask / clear / status
    localparam int IRQ_LSB = 1;

endpackage

// File: rtl/regwin_seq.sv
module regwin_seq
    import regwin_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int AW      = 8,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_wr,
    input  logic [AW-1:0] win_addr,
    input  logic [DW-1:0] win_byte,
    input  logic          win_dir,
    output logic          busy,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wbyte_q,
    output logic          dir_q,
    output logic [DW-1:0] rbyte_q,
    output logic [AW-1:0] bank_addr,
    output logic [DW-1:0] bank_wdata,
    output logic          bank_we,
    output logic          bank_re,
    input  logic [DW-1:0] bank_rdata
);

    localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CW-1:0] WAIT_LAST = CW'(LATENCY - 2);

    win_state_e    state, state_nx;
    logic [CW-1:0] cnt;
    logic          accept;

    assign accept = win_wr && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (win_wr) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT:  if (cnt == WAIT_LAST) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        bank_we = 1'b0;
        bank_re = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: begin
                busy    = 1'b1;
                bank_we = dir_q;
                bank_re = !dir_q;
            end
            ST_WAIT:  busy = 1'b1;
            default:  ;
        endcase
    end

    assign bank_addr  = addr_q;
    assign bank_wdata = wbyte_q;

    // wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (state != ST_WAIT) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // captured command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wbyte_q <= '0;
            dir_q   <= 1'b0;
        end else if (accept) begin
            addr_q  <= win_addr;
            wbyte_q <= win_byte;
            dir_q   <= win_dir;
        end
    end

    // read result captured on the first wait cycle of a read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rbyte_q <= '0;
        else if (state == ST_WAIT && cnt == '0 && !dir_q)
            rbyte_q <= bank_rdata;
    end

    // checker state: consecutive busy cycles seen before this one
    logic [3:0] chk_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chk_run <= '0;
        else if (busy) chk_run <= chk_run + 1'b1;
        else           chk_run <= '0;
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !busy) |=> busy);
    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (chk_run < 4'(LATENCY)));
    // R2
    busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_run == 4'(LATENCY)));
    // R5
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && busy) |=> ($stable(addr_q) && $stable(wbyte_q) && $stable(dir_q)));
    // R3
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_we, bank_re}));
    // R3
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we || bank_re) |-> (busy && !$past(busy)));

endmodule

// File: rtl/regwin_irq.sv
module regwin_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_wr,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] wbits,
    input  logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] stat_q,
    output logic            irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wbits;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic clr_hit;
        assign clr_hit = clr_wr && wbits[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stat_q[i] <= 1'b0;
            else if (evt[i])  stat_q[i] <= 1'b1;
            else if (clr_hit) stat_q[i] <= 1'b0;
        end

        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> stat_q[i]);
        // R7
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && !evt[i]) |=> !stat_q[i]);
        // R6
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !clr_hit) |=> stat_q[i]);
    end

    assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int HW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [1:0]    host_sel,
    input  logic [HW-1:0] host_wdata,
    output logic [HW-1:0] host_rdata,
    input  logic          tx_evt,
    input  logic          rx_evt,
    output logic          irq,
    output logic [AW-1:0] bank_addr,
    output logic [DW-1:0] bank_wdata,
    output logic          bank_we,
    output logic          bank_re,
    input  logic [DW-1:0] bank_rdata
);

    localparam int NSRC = 2;

    logic          win_wr, mask_wr, clr_wr;
    logic          busy, dir_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wbyte_q, rbyte_q;
    logic [NSRC-1:0] mask_q, stat_q;

    assign win_wr  = host_wr && (host_sel == SEL_WIN);
    assign mask_wr = host_wr && (host_sel == SEL_MASK);
    assign clr_wr  = host_wr && (host_sel == SEL_CLR);

    regwin_seq #(.LATENCY(LATENCY), .AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_wr     (win_wr),
        .win_addr   (host_wdata[WIN_ADDR_LSB +: AW]),
        .win_byte   (host_wdata[WIN_WDAT_LSB +: DW]),
        .win_dir    (host_wdata[WIN_DIR_BIT]),
        .busy       (busy),
        .addr_q     (addr_q),
        .wbyte_q    (wbyte_q),
        .dir_q      (dir_q),
        .rbyte_q    (rbyte_q),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata),
        .bank_we    (bank_we),
        .bank_re    (bank_re),
        .bank_rdata (bank_rdata)
    );

    regwin_irq #(.NSRC(NSRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (mask_wr),
        .clr_wr  (clr_wr),
        .wbits   (host_wdata[IRQ_LSB +: NSRC]),
        .evt     ({rx_evt, tx_evt}),
        .mask_q  (mask_q),
        .stat_q  (stat_q),
        .irq     (irq)
    );

    always_comb begin
        host_rdata = '0;
        unique case (host_sel)
            SEL_WIN: begin
                host_rdata[WIN_ADDR_LSB +: AW] = addr_q;
                host_rdata[WIN_WDAT_LSB +: DW] = wbyte_q;
                host_rdata[WIN_DIR_BIT]        = dir_q;
                host_rdata[WIN_BUSY_BIT]       = busy;
                host_rdata[WIN_RDAT_LSB +: DW] = rbyte_q;
            end
            SEL_MASK: host_rdata[IRQ_LSB +: NSRC] = mask_q;
            SEL_CLR:  ;
            SEL_STAT: host_rdata[IRQ_LSB +: NSRC] = stat_q;
            default:  ;
        endcase
    end

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    // R11
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == SEL_STAT && !tx_evt && !rx_evt) |=> $stable(stat_q));

endmodule

// File: tb/regwin_bridge_test.sv
module regwin_bridge_test;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_evt = 1'b0, rx_evt = 1'b0;
    logic        irq;
    logic [7:0]  bank_addr, bank_wdata, bank_rdata;
    logic        bank_we, bank_re;

    int n_chk = 0, n_fail = 0;
    int n_strobe = 0;
    logic [7:0] last_sa;
    logic [7:0] mem [256];
    logic [7:0] rd_reg = 8'h00;

    always #5 clk = ~clk;

    regwin_bridge #(.LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_evt(tx_evt), .rx_evt(rx_evt), .irq(irq),
        .bank_addr(bank_addr), .bank_wdata(bank_wdata),
        .bank_we(bank_we), .bank_re(bank_re), .bank_rdata(bank_rdata)
    );

    // bank model: registered read, one cycle after strobe
    always @(posedge clk) begin
        if (bank_we) mem[bank_addr] <= bank_wdata;
        if (bank_re) rd_reg <= mem[bank_addr];
        if (bank_we || bank_re) begin
            n_strobe = n_strobe + 1;
            last_sa  = bank_addr;
        end
    end
    assign bank_rdata = rd_reg;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] sel, input logic [31:0] d);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] sel, output logic [31:0] d);
        host_sel = sel;
        #1;
        d = host_rdata;
    endtask

    task automatic busy_len(output int n);
        logic [31:0] w;
        n = 0;
        hread(2'd0, w);
        while (w[23] && n < 50) begin
            n++;
            @(negedge clk);
            hread(2'd0, w);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w, prev;
        int n, s0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        hread(2'd0, w); check(w == 0, "R10 window", w, 0);
        hread(2'd1, w); check(w == 0, "R10 mask", w, 0);
        hread(2'd3, w); check(w == 0, "R10 status", w, 0);
        check(irq == 1'b0, "R10 irq", {31'b0, irq}, 0);

        // R2 R3 write sweep over every address
        for (int a = 0; a < 256; a++) begin
            s0 = n_strobe;
            hwrite(2'd0, {8'h00, 7'b0, 1'b1, pat(a), 8'(a)});
            busy_len(n);
            if (a < 4) check(n == LAT, "R2 busy length", n, LAT);
            check(n_strobe == s0 + 1 && last_sa == 8'(a), "R3 one write strobe", n_strobe - s0, 1);
            check(mem[a] == pat(a), "R3 bank byte", mem[a], pat(a));
        end
        hread(2'd0, w);
        check(w[31:24] == 8'h00, "R4 write keeps read field", w[31:24], 0);

        // R1 R4 read sweep
        for (int a = 0; a < 256; a++) begin
            s0 = n_strobe;
            hwrite(2'd0, {16'h0000, 8'hC3, 8'(a)});
            busy_len(n);
            if (a < 4) check(n == LAT, "R2 read busy length", n, LAT);
            hread(2'd0, w);
            check(w == {pat(a), 1'b0, 6'b0, 1'b0, 8'hC3, 8'(a)}, "R1 R4 read window",
                  w, {pat(a), 16'h00C3, 8'(a)});
            check(n_strobe == s0 + 1, "R4 one read strobe", n_strobe - s0, 1);
        end

        // R4 write after read keeps read field
        hwrite(2'd0, {8'h00, 7'b0, 1'b1, 8'h5A, 8'h7F});
        busy_len(n);
        hread(2'd0, w);
        check(w[31:24] == pat(255), "R4 read field kept", w[31:24], pat(255));
        check(w[16] == 1'b1 && w[15:8] == 8'h5A, "R1 dir and byte", w, 32'h15A7F);

        // R5 window write while busy is ignored
        s0 = n_strobe;
        hwrite(2'd0, {8'h00, 7'b0, 1'b1, 8'h55, 8'h10});
        hwrite(2'd0, {8'h00, 7'b0, 1'b1, 8'hAA, 8'h20});
        busy_len(n);
        check(n == LAT - 1, "R5 busy not stretched", n, LAT - 1);
        check(n_strobe == s0 + 1 && last_sa == 8'h10, "R5 single strobe", n_strobe - s0, 1);
        hread(2'd0, w);
        check(w[16:0] == {1'b1, 8'h55, 8'h10}, "R5 fields kept", w[16:0], 32'h15510);
        check(mem[8'h20] == pat(32), "R5 bank untouched", mem[8'h20], pat(32));

        // R6 sticky set
        tx_evt = 1'b1; @(negedge clk); tx_evt = 1'b0;
        repeat (3) @(negedge clk);
        hread(2'd3, w); check(w == 32'h2, "R6 tx sticky", w, 2);
        rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0;
        hread(2'd3, w); check(w == 32'h6, "R6 rx set", w, 6);

        // R11 status write ignored, clear reads zero
        hwrite(2'd3, 32'h0);
        hread(2'd3, w); check(w == 32'h6, "R11 status write ignored", w, 6);
        hread(2'd2, w); check(w == 32'h0, "R11 clear reads zero", w, 0);

        // R7 clear
        hwrite(2'd2, 32'h0);
        hread(2'd3, w); check(w == 32'h6, "R7 zero leaves bits", w, 6);
        hwrite(2'd2, 32'h4);
        hread(2'd3, w); check(w == 32'h2, "R7 clear rx", w, 2);

        // R8 set wins over clear
        tx_evt = 1'b1;
        hwrite(2'd2, 32'h2);
        tx_evt = 1'b0;
        hread(2'd3, w); check(w == 32'h2, "R8 set wins", w, 2);
        hwrite(2'd2, 32'h2);
        hread(2'd3, w); check(w == 32'h0, "R7 clear tx", w, 0);

        // R11 mask keeps only bits 1 and 2
        hwrite(2'd1, 32'hFFFF_FFFF);
        hread(2'd1, w); check(w == 32'h6, "R11 mask bits", w, 6);

        // R9 mask by status sweep
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                hwrite(2'd2, 32'h6);
                tx_evt = s[0]; rx_evt = s[1];
                @(negedge clk);
                tx_evt = 1'b0; rx_evt = 1'b0;
                hwrite(2'd1, 32'(m) << 1);
                hread(2'd1, prev);
                check(prev == (32'(m) << 1), "R9 mask readback", prev, 32'(m) << 1);
                check(irq == ((m & s) != 0), "R9 irq", {31'b0, irq}, {31'b0, ((m & s) != 0)});
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule